// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Target Predictor

This block sits beside the fetch stage. Every cycle it takes the fetch address, looks it up in a direction table and in a small target cache, and on the next cycle reports three things: whether the branch is expected to be taken, whether the target cache holds an entry for that address, and the address fetch should use next. When the branch at that address is predicted taken and the target cache hits, the next address is the cached target, so fetch is redirected with no decode step. In every other case the next address is the fetch address plus four.

When a branch resolves later in the pipeline, the resolving stage presents its address, its actual direction and its actual target on the update port. The block compares this against its stored state and raises a flush request with the correct restart address if fetch went the wrong way. It then trains the direction entry and, for taken branches, writes the target cache. A build parameter chooses the direction scheme. In the one-bit scheme each entry simply follows the last outcome. In the two-bit scheme each entry is a saturating counter that changes its guess only after two wrong guesses in a row.

Top module: `fetch_bpred`

## Requirements
- R1: During reset and on the first cycle after it, pred_taken, pred_hit and flush are 0. Every direction entry starts at not taken (counter value 1 in two-bit mode, bit value 0 in one-bit mode), and every target cache entry starts invalid.
- R2: The direction entry is selected by fetch_pc[7:2]. A lookup presented before clock edge k appears on pred_taken, pred_hit and pred_next_pc after edge k.
- R3: In two-bit mode the entry is a counter from 0 to 3 that predicts taken when it is 2 or 3. A taken update adds one and stops at 3; a not-taken update subtracts one and stops at 0.
- R4: In one-bit mode an update stores the actual direction, so a single wrong guess inverts the prediction.
- R5: The target cache has 16 entries selected by PC[5:2], each with a valid bit, a tag equal to PC[31:6] and a 32-bit target. pred_hit is 1 only when the selected entry is valid and its tag equals the fetch tag.
- R6: An update with upd_taken=1 writes its target cache entry (valid, tag, target), replacing any entry already there. An update with upd_taken=0 leaves the target cache unchanged.
- R7: pred_next_pc equals the cached target when pred_taken and pred_hit are both 1. Otherwise it equals the looked-up fetch address plus 4.
- R8: After the edge that takes an update, flush is 1 when the stored direction differs from upd_taken, or when upd_taken=1 and the target cache did not hold a valid entry with the matching tag and target. flush_pc is upd_target for a taken update and upd_pc+4 for a not-taken one. flush is 0 after any edge without an update.
- R9: When a lookup and an update reach the same entries on the same edge, the lookup returns the contents from before that update.
- R10: For a nested loop in which the inner branch is taken three times and then falls through, the inner branch raises flush twice per outer pass in one-bit mode and once per pass in two-bit mode, from the second pass onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | PC_W | Actual target of the resolved branch |
| pred_taken | output | 1 | Direction guess for the previous cycle's fetch address |
| pred_hit | output | 1 | Target cache held that address |
| pred_next_pc | output | PC_W | Predicted next fetch address |
| flush | output | 1 | Fetch went the wrong way for the last update |
| flush_pc | output | PC_W | Restart address that goes with flush |

## Verification
The hardest behaviour to reach from the ports is the steady alternation of training and misprediction. Reaching it needs a long history at a single entry, a lookup and an update hitting that entry on the same edge, and tag aliasing in the target cache. The stimulus walks one address through full counter saturation in both directions while it is also being fetched. It then plants two addresses that share a cache index but differ in tag, runs a random mix over a small set of colliding addresses, and finally replays a nested loop. Two instances, one per mode, get the same inputs and are compared with a behavioural model on every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic {
    PRED_1BIT = 1'b0,
    PRED_2BIT = 1'b1
  } pred_mode_e;

  // weakly not-taken start value for the saturating counters
  localparam logic [1:0] CNT_INIT = 2'b01;

  function automatic logic [1:0] cnt_train(input logic [1:0] cur, input logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
  parameter bp_pkg::pred_mode_e MODE = bp_pkg::PRED_2BIT,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_taken_now,
  input  logic             up_en,
  input  logic             up_taken
);
  localparam int DEPTH = 1 << IDX_W;

  generate
    if (MODE == bp_pkg::PRED_2BIT) begin : g_two_bit
      logic [1:0] cnt [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) cnt[i] <= bp_pkg::CNT_INIT;
        end else if (up_en) begin
          cnt[up_idx] <= bp_pkg::cnt_train(cnt[up_idx], up_taken);
        end
      end

      always_ff @(posedge clk) begin
        if (rst) rd_taken <= 1'b0;
        else     rd_taken <= cnt[rd_idx][1];
      end

      assign up_taken_now = cnt[up_idx][1];
    end else begin : g_one_bit
      logic dir [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) dir[i] <= 1'b0;
        end else if (up_en) begin
          dir[up_idx] <= up_taken;
        end
      end

      always_ff @(posedge clk) begin
        if (rst) rd_taken <= 1'b0;
        else     rd_taken <= dir[rd_idx];
      end

      assign up_taken_now = dir[up_idx];
    end
  endgenerate

endmodule

// File: rtl/bp_target_buf.sv
module bp_target_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = PC_W - IDX_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PC_W-1:0]  lk_target,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [TAG_W-1:0] up_tag,
  output logic             up_hit_now,
  output logic [PC_W-1:0]  up_target_now,
  input  logic             wr_en,
  input  logic [PC_W-1:0]  wr_target
);
  localparam int DEPTH = 1 << IDX_W;

  logic             vld [DEPTH];
  logic [TAG_W-1:0] tag [DEPTH];
  logic [PC_W-1:0]  tgt [DEPTH];

  // valid bits need a reset; tag and target arrays stay RAM-style
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) vld[i] <= 1'b0;
    end else if (wr_en) begin
      vld[up_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag[up_idx] <= up_tag;
      tgt[up_idx] <= wr_target;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lk_hit <= 1'b0;
    else     lk_hit <= vld[lk_idx] && (tag[lk_idx] == lk_tag);
  end

  always_ff @(posedge clk) begin
    lk_target <= tgt[lk_idx];
  end

  assign up_hit_now    = vld[up_idx] && (tag[up_idx] == up_tag);
  assign up_target_now = tgt[up_idx];

endmodule

// File: rtl/fetch_bpred.sv
module fetch_bpred #(
  parameter int PC_W      = 32,
  parameter int PHT_IDX_W = 6,
  parameter int BTB_IDX_W = 4,
  parameter bp_pkg::pred_mode_e MODE = bp_pkg::PRED_2BIT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  output logic            pred_taken,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_next_pc,
  output logic            flush,
  output logic [PC_W-1:0] flush_pc
);
  localparam int TAG_W = PC_W - BTB_IDX_W - 2;
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  logic [PC_W-1:0] pc_q;
  logic            dir_q;
  logic            hit_q;
  logic [PC_W-1:0] tgt_q;
  logic            dir_now;
  logic            hit_now;
  logic [PC_W-1:0] tgt_now;
  logic            wrong_way;

  bp_dir_table #(.MODE(MODE), .IDX_W(PHT_IDX_W)) dir_i (
    .clk          (clk),
    .rst          (rst),
    .rd_idx       (fetch_pc[PHT_IDX_W+1:2]),
    .rd_taken     (dir_q),
    .up_idx       (upd_pc[PHT_IDX_W+1:2]),
    .up_taken_now (dir_now),
    .up_en        (upd_valid),
    .up_taken     (upd_taken)
  );

  bp_target_buf #(.PC_W(PC_W), .IDX_W(BTB_IDX_W), .TAG_W(TAG_W)) tb_i (
    .clk           (clk),
    .rst           (rst),
    .lk_idx        (fetch_pc[BTB_IDX_W+1:2]),
    .lk_tag        (fetch_pc[PC_W-1:BTB_IDX_W+2]),
    .lk_hit        (hit_q),
    .lk_target     (tgt_q),
    .up_idx        (upd_pc[BTB_IDX_W+1:2]),
    .up_tag        (upd_pc[PC_W-1:BTB_IDX_W+2]),
    .up_hit_now    (hit_now),
    .up_target_now (tgt_now),
    .wr_en         (upd_valid && upd_taken),
    .wr_target     (upd_target)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= fetch_pc;
  end

  assign pred_taken   = dir_q;
  assign pred_hit     = hit_q;
  assign pred_next_pc = (dir_q && hit_q) ? tgt_q : pc_q + PC_STEP;

  // fetch went wrong if the direction disagreed, or a taken branch
  // could not have been redirected to the right target
  always_comb begin
    wrong_way = (dir_now != upd_taken) ||
                (upd_taken && !(hit_now && (tgt_now == upd_target)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flush    <= 1'b0;
      flush_pc <= '0;
    end else begin
      flush <= upd_valid && wrong_way;
      if (upd_valid) flush_pc <= upd_taken ? upd_target : upd_pc + PC_STEP;
    end
  end

endmodule

// File: rtl/fetch_bpred_chk.sv
module fetch_bpred_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetch_pc,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic            pred_taken,
  input logic            pred_hit,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            flush,
  input logic [PC_W-1:0] flush_pc
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pred_taken && !pred_hit && !flush));

  // R8
  flush_needs_update_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(upd_valid));

  // R8
  fallthrough_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_valid && !upd_taken)) |-> (flush_pc == $past(upd_pc) + 4));

  // R7
  seq_next_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !(pred_taken && pred_hit)) |-> (pred_next_pc == $past(fetch_pc) + 4));

  // R6
  alloc_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(upd_valid && upd_taken, 2) &&
     ($past(fetch_pc) == $past(upd_pc, 2))) |-> pred_hit);

endmodule

bind fetch_bpred fetch_bpred_chk #(.PC_W(PC_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .fetch_pc     (fetch_pc),
  .upd_valid    (upd_valid),
  .upd_pc       (upd_pc),
  .upd_taken    (upd_taken),
  .pred_taken   (pred_taken),
  .pred_hit     (pred_hit),
  .pred_next_pc (pred_next_pc),
  .flush        (flush),
  .flush_pc     (flush_pc)
);

// File: tb/fetch_bpred_tb_top.sv
`timescale 1ns/1ps
module fetch_bpred_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;

  logic        t2, h2, f2, t1, h1, f1;
  logic [31:0] n2, fp2, n1, fp1;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fetch_bpred #(.MODE(bp_pkg::PRED_2BIT)) dut_i (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
    .pred_taken(t2), .pred_hit(h2), .pred_next_pc(n2), .flush(f2), .flush_pc(fp2)
  );

  fetch_bpred #(.MODE(bp_pkg::PRED_1BIT)) dut_1b_i (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_target(upd_target),
    .pred_taken(t1), .pred_hit(h1), .pred_next_pc(n1), .flush(f1), .flush_pc(fp1)
  );

  // behavioural model state
  int          m_cnt [64];
  bit          m_bit [64];
  bit          m_vld [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];

  bit          e_t2, e_t1, e_hit, e_f2, e_f1;
  logic [31:0] e_n2, e_n1, e_fp;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    int pi, bi, ui, ubi;
    bit hit_lk, ubh, wrong2, wrong1;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 64; i++) begin m_cnt[i] = 1; m_bit[i] = 0; end
      for (int i = 0; i < 16; i++) m_vld[i] = 0;
      e_t2 = 0; e_t1 = 0; e_hit = 0; e_f2 = 0; e_f1 = 0;
      e_n2 = 32'd4; e_n1 = 32'd4;
    end else begin
      pi = int'(fetch_pc[7:2]);
      bi = int'(fetch_pc[5:2]);
      hit_lk = m_vld[bi] && (m_tag[bi] == fetch_pc[31:6]);
      e_hit = hit_lk;
      e_t2 = (m_cnt[pi] >= 2);
      e_t1 = m_bit[pi];
      e_n2 = (e_t2 && hit_lk) ? m_tgt[bi] : fetch_pc + 32'd4;
      e_n1 = (e_t1 && hit_lk) ? m_tgt[bi] : fetch_pc + 32'd4;
      e_f2 = 0; e_f1 = 0;
      if (upd_valid) begin
        ui  = int'(upd_pc[7:2]);
        ubi = int'(upd_pc[5:2]);
        ubh = m_vld[ubi] && (m_tag[ubi] == upd_pc[31:6]) && (m_tgt[ubi] == upd_target);
        wrong2 = ((m_cnt[ui] >= 2) != upd_taken) || (upd_taken && !ubh);
        wrong1 = (m_bit[ui] != upd_taken) || (upd_taken && !ubh);
        e_f2 = wrong2; e_f1 = wrong1;
        e_fp = upd_taken ? upd_target : upd_pc + 32'd4;
        if (upd_taken && m_cnt[ui] < 3) m_cnt[ui]++;
        if (!upd_taken && m_cnt[ui] > 0) m_cnt[ui]--;
        m_bit[ui] = upd_taken;
        if (upd_taken) begin
          m_vld[ubi] = 1; m_tag[ubi] = upd_pc[31:6]; m_tgt[ubi] = upd_target;
        end
      end
    end
    @(negedge clk);
    chk(t2 == e_t2, "R3", "two-bit direction", 32'(t2), 32'(e_t2));
    chk(t1 == e_t1, "R4", "one-bit direction", 32'(t1), 32'(e_t1));
    chk(h2 == e_hit && h1 == e_hit, "R5", "target hit", 32'(h2), 32'(e_hit));
    chk(n2 == e_n2, "R7", "next pc two-bit", n2, e_n2);
    chk(n1 == e_n1, "R7", "next pc one-bit", n1, e_n1);
    chk(f2 == e_f2, "R8", "flush two-bit", 32'(f2), 32'(e_f2));
    chk(f1 == e_f1, "R8", "flush one-bit", 32'(f1), 32'(e_f1));
    if (e_f2) chk(fp2 == e_fp, "R8", "restart two-bit", fp2, e_fp);
    if (e_f1) chk(fp1 == e_fp, "R8", "restart one-bit", fp1, e_fp);
  endtask

  task automatic drive(input logic [31:0] fpc, input bit uv, input logic [31:0] upc,
                       input bit tk, input logic [31:0] tgt);
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = tk; upd_target = tgt;
    step();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(32'h0, 0, 32'h0, 0, 32'h0);
    drive(32'h0, 0, 32'h0, 0, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fl1, fl2;
    logic [31:0] pcs [8];
    do_reset();
    // R1 and R2: first lookups after reset predict not taken, fall through
    drive(32'h0000_0040, 0, 32'h0, 0, 32'h0);
    chk(!t2 && !t1 && !h2 && !f2, "R1", "quiet after reset", 32'(t2), 32'h0);
    chk(n2 == 32'h44, "R2", "lookup latency", n2, 32'h44);

    // R3/R4/R9: saturate one entry while fetching it on the same edge
    for (int i = 0; i < 5; i++) drive(32'h40, 1, 32'h40, 1, 32'h0000_0800);
    drive(32'h40, 0, 32'h0, 0, 32'h0);
    chk(t2 && h2 && n2 == 32'h800, "R9", "trained redirect", n2, 32'h800);
    for (int i = 0; i < 5; i++) drive(32'h40, 1, 32'h40, 0, 32'h0);
    drive(32'h40, 0, 32'h0, 0, 32'h0);

    // R5/R6: two addresses sharing a cache index but not a tag
    drive(32'h1000, 1, 32'h1000, 1, 32'h2000);
    drive(32'h1000, 1, 32'h3000, 0, 32'h0);
    drive(32'h3000, 0, 32'h0, 0, 32'h0);
    chk(!h2, "R5", "alias tag miss", 32'(h2), 32'h0);
    drive(32'h1000, 1, 32'h3000, 1, 32'h4000);
    drive(32'h1000, 0, 32'h0, 0, 32'h0);
    chk(!h2, "R6", "entry replaced", 32'(h2), 32'h0);

    // mixed traffic over colliding addresses
    pcs = '{32'h100, 32'h104, 32'h140, 32'h200, 32'h1100, 32'h40, 32'h300, 32'h2104};
    for (int i = 0; i < 400; i++)
      drive(pcs[$urandom_range(7)], 1'($urandom_range(1)), pcs[$urandom_range(7)],
            1'($urandom_range(1)), 32'h8000 + 32'($urandom_range(3)) * 32'h40);

    // R10: nested loop, inner branch at 0x200, outer at 0x244
    do_reset();
    for (int p = 0; p < 5; p++) begin
      fl1 = 0; fl2 = 0;
      for (int k = 0; k < 4; k++) begin
        drive(32'h200, 1, 32'h200, (k < 3), 32'h1C0);
        if (f1) fl1++;
        if (f2) fl2++;
      end
      drive(32'h244, 1, 32'h244, 1, 32'h100);
      if (p > 0) begin
        chk(fl1 == 2, "R10", "one-bit inner flushes", 32'(fl1), 32'd2);
        chk(fl2 == 1, "R10", "two-bit inner flushes", 32'(fl2), 32'd1);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule